// File: doc/BRIEF.md
# Sparse End-Around-Carry Adder Modulo 2^n − 3

This block adds two n-bit residues for a residue-arithmetic datapath whose channel modulus is 2^n − 3. The modulus is n bits wide. The three codes at the top of the n-bit range (2^n − 3, 2^n − 2, 2^n − 1) are accepted and produced as second spellings of 0, 1 and 2. The arithmetic rule is simple. When the true integer sum fits in n bits, it is returned unchanged. When it overflows, the lost weight 2^n is congruent to 3, so 3 is added back and the result is cut to n bits.

The arithmetic path has four stages:
- A half-adder row turns both operands into a carry-save pair, so the weight-3 correction can enter at bits 0 and 1 without colliding with a second carry.
- A sparse prefix network computes carries only at every group boundary (default group width 4), including the end-around term.
- A modified carry-select group for the lowest group applies bit 1's special carry rule.
- Ordinary carry-select groups handle every other group.

The combinational result is captured in one output register, following the two-process coding convention of the code base. The output therefore shows the sum of the operands present at the previous rising clock edge. The width N must be a multiple of the group width and at least twice it. Widths 8, 16, 32 and 64 are the intended sizes.

Top module: `rmod_sparse_add`

## Requirements
- R1: While rst_n is sampled low at a rising edge, sum_o is all zeros after that edge, whatever the operands.
- R2: If a_i + b_i < 2^N, then after the next rising edge sum_o equals a_i + b_i.
- R3: If a_i + b_i ≥ 2^N, then after the next rising edge sum_o equals (a_i + b_i + 3) mod 2^N.
- R4: The edge of the wrap decision is exact. A sum of exactly 2^N gives 3, and a sum of 2^N − 1 gives 2^N − 1.
- R5: Operands given in their alternate spellings (2^N − 3, 2^N − 2, 2^N − 1 standing for 0, 1, 2) give a result congruent to the intended residue sum. An alternate zero plus zero stays 2^N − 3.
- R6: The two sums whose correction overflows again are returned as truncated. A sum of 2^(N+1) − 3 gives 0 and a sum of 2^(N+1) − 2 gives 1. These are the only results not congruent to a_i + b_i.
- R7: For every other operand pair, sum_o mod (2^N − 3) equals (a_i + b_i) mod (2^N − 3).
- R8: The result has one cycle of latency. A change of operands is not visible at sum_o before the next rising edge. With operands held and reset inactive, sum_o holds as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous reset, active low; clears the result register |
| a_i | input | N | First operand residue |
| b_i | input | N | Second operand residue |
| sum_o | output | N | Registered modular sum |

## Verification
The bound checker compares every registered result against the integer reference rule on every cycle. This covers the no-wrap and wrap cases, the exact 2^N boundary, the two double-overflow sums, the reset value and the hold-when-stable behaviour. Congruence modulo 2^N − 3 needs a true remainder, so only the bench scenarios show it. The same applies to the meaning of the alternate encodings and to the fact that an operand change is not visible before the clock edge. The bench covers these with directed corner pairs and a few thousand pseudo-random pairs.

// File: rtl/rmod_pkg.sv
package rmod_pkg;

    // Generate/propagate pair carried through the prefix tree.
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Combine a more significant span (hi) with the span directly below it (lo).
    function automatic gp_t gp_merge(gp_t hi, gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/rmod_hrow.sv
// Half-adder row: operands -> carry-save pair plus the top carry bit.
module rmod_hrow #(
    parameter int N = 32
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] u_o,
    output logic [N-1:0] w_o,
    output logic         vtop_o
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            assign u_o[i] = a_i[i] ^ b_i[i];
            if (i == 0) begin : g_lsb
                // Bit 0 of the shifted carry row is free: it receives the wrap term later.
                assign w_o[i] = 1'b0;
            end else begin : g_up
                assign w_o[i] = a_i[i-1] & b_i[i-1];
            end
        end
    endgenerate

    assign vtop_o = a_i[N-1] & b_i[N-1];
endmodule

// File: rtl/rmod_prefix.sv
// Sparse prefix network over groups with the end-around weight-3 correction.
// Produces the carry into every group; group 0 receives the wrap flag itself.
module rmod_prefix
    import rmod_pkg::*;
#(
    parameter int N  = 32,
    parameter int GW = 4
) (
    input  logic [N-1:0]     u_i,
    input  logic [N-1:0]     w_i,
    input  logic             vtop_i,
    output logic [N/GW-1:0]  cin_o
);
    localparam int NG = N / GW;
    localparam int LV = $clog2(NG);

    gp_t  lvl [LV+1][NG];
    logic wrap;

    always_comb begin
        // Group-level generate and (modified) propagate.
        for (int k = 0; k < NG; k++) begin : grp
            logic ga, pa, gb, pb;
            ga = 1'b0;
            pa = 1'b1;
            for (int j = 0; j < GW; j++) begin
                gb = u_i[k*GW+j] & w_i[k*GW+j];
                pb = u_i[k*GW+j] ^ w_i[k*GW+j];
                ga = gb | (pb & ga);
                if (k != 0 || j >= 2) pa = pa & pb;
            end
            // Lowest group: the injected 3 reaches bit 2 when bit 1 propagates or bit 0 is set.
            if (k == 0) pa = pa & ((u_i[1] ^ w_i[1]) | u_i[0]);
            lvl[0][k].g = ga;
            lvl[0][k].p = pa;
        end
        // Kogge-Stone style spans over the groups.
        for (int l = 0; l < LV; l++) begin
            for (int k = 0; k < NG; k++) begin
                if (k >= (1 << l))
                    lvl[l+1][k] = gp_merge(lvl[l][k], lvl[l][(k >= (1 << l)) ? k - (1 << l) : 0]);
                else
                    lvl[l+1][k] = lvl[l][k];
            end
        end
        // End-around: total overflow is either the carry-save top bit or the row carry out.
        wrap     = vtop_i | lvl[LV][NG-1].g;
        cin_o[0] = wrap;
        for (int k = 1; k < NG; k++)
            cin_o[k] = lvl[LV][k-1].g | (lvl[LV][k-1].p & wrap);
    end
endmodule

// File: rtl/rmod_cselg.sv
// One carry-select group. LOW=1 selects the lowest-group variant, where cin_i
// is the wrap flag and the correction value 3 enters at bits 0 and 1.
module rmod_cselg #(
    parameter int GW  = 4,
    parameter bit LOW = 1'b0
) (
    input  logic [GW-1:0] u_i,
    input  logic [GW-1:0] w_i,
    input  logic          cin_i,
    output logic [GW-1:0] s_o
);
    logic [GW-1:0] p;
    assign p = u_i ^ w_i;

    generate
        if (LOW) begin : g_low
            logic [GW-1:2] c;
            always_comb begin
                c[2] = (u_i[1] & w_i[1]) | (p[1] & u_i[0] & w_i[0])
                     | (cin_i & (p[1] | u_i[0]));
                for (int i = 2; i < GW - 1; i++)
                    c[i+1] = (u_i[i] & w_i[i]) | (p[i] & c[i]);
                s_o[0] = p[0] ^ cin_i;
                // Bit 1: select between plain and corrected sum on the wrap flag.
                s_o[1] = cin_i ? (p[1] ^ ~u_i[0]) : (p[1] ^ (u_i[0] & w_i[0]));
                for (int i = 2; i < GW; i++)
                    s_o[i] = p[i] ^ c[i];
            end
        end else begin : g_std
            logic [GW-1:0] c0, c1;
            always_comb begin
                c0[0] = 1'b0;
                c1[0] = 1'b1;
                for (int i = 1; i < GW; i++) begin
                    c0[i] = (u_i[i-1] & w_i[i-1]) | (p[i-1] & c0[i-1]);
                    c1[i] = (u_i[i-1] & w_i[i-1]) | (p[i-1] & c1[i-1]);
                end
                s_o = cin_i ? (p ^ c1) : (p ^ c0);
            end
        end
    endgenerate
endmodule

// File: rtl/rmod_sparse_add.sv
// Modulo 2^N-3 adder: carry-save row, sparse prefix with end-around carry,
// carry-select groups, registered result.
module rmod_sparse_add #(
    parameter int N  = 32,
    parameter int GW = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] sum_o
);
    localparam int NG = N / GW;

    typedef struct packed {
        logic [N-1:0] sum;
    } st_t;

    logic [N-1:0]  u, w;
    logic          vtop;
    logic [NG-1:0] gcin;
    logic [N-1:0]  sum_c;
    st_t           st_d, st_q;

    rmod_hrow #(.N(N)) hrow_i (
        .a_i    (a_i),
        .b_i    (b_i),
        .u_o    (u),
        .w_o    (w),
        .vtop_o (vtop)
    );

    rmod_prefix #(.N(N), .GW(GW)) pfx_i (
        .u_i    (u),
        .w_i    (w),
        .vtop_i (vtop),
        .cin_o  (gcin)
    );

    generate
        for (genvar k = 0; k < NG; k++) begin : g_grp
            rmod_cselg #(.GW(GW), .LOW(k == 0)) cs_i (
                .u_i   (u[k*GW +: GW]),
                .w_i   (w[k*GW +: GW]),
                .cin_i (gcin[k]),
                .s_o   (sum_c[k*GW +: GW])
            );
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.sum = sum_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_o = st_q.sum;
endmodule

// File: rtl/rmod_sparse_add_chk.sv
module rmod_sparse_add_chk #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] a_i,
    input logic [N-1:0] b_i,
    input logic [N-1:0] sum_o
);
    localparam logic [N-1:0] THREE = N'(3);
    localparam logic [N:0]   DBL_LIM = {(N+1){1'b1}} - (N+1)'(3);

    logic [N:0]   tot;
    logic [N-1:0] tot_p3;
    assign tot    = {1'b0, a_i} + {1'b0, b_i};
    assign tot_p3 = tot[N-1:0] + THREE;

    // R1
    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> sum_o == '0);

    // R2
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tot[N] |=> sum_o == $past(tot[N-1:0]));

    // R3
    p_wrap_add3_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tot[N] |=> sum_o == $past(tot_p3));

    // R4
    p_exact_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tot == {1'b1, {N{1'b0}}}) |=> sum_o == THREE);

    // R6
    p_double_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tot > DBL_LIM) |=> sum_o == {{(N-1){1'b0}}, $past(tot[1])});

    // R8
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(a_i) && $stable(b_i)) |=> $stable(sum_o));
endmodule

bind rmod_sparse_add rmod_sparse_add_chk #(.N(N)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .a_i   (a_i),
    .b_i   (b_i),
    .sum_o (sum_o)
);

// File: tb/rmod_sparse_add_tb_top.sv
`timescale 1ns/1ps
module rmod_sparse_add_tb_top;
    localparam int W = 32;
    localparam logic [63:0] MODV = (64'd1 << W) - 64'd3;
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_r = '0, b_r = '0;
    logic [W-1:0] sum_w;
    int n_chk = 0, n_fail = 0, n_dbl = 0;

    always #5 clk = ~clk;

    rmod_sparse_add #(.N(W)) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (a_r),
        .b_i   (b_r),
        .sum_o (sum_w)
    );

    function automatic logic [W-1:0] ref_sum(logic [W-1:0] a, logic [W-1:0] b);
        logic [W:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[W] ? (t[W-1:0] + W'(3)) : t[W-1:0];
    endfunction

    task automatic chk(input string rq, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", rq, got, exp);
        end
    endtask

    task automatic chk_mod(input string rq, input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [W-1:0] got);
        logic [63:0] t;
        t = {32'd0, a} + {32'd0, b};
        n_chk++;
        if (({32'd0, got} % MODV) != (t % MODV)) begin
            n_fail++;
            $display("FAIL %s: actual residue=%0d expected residue=%0d",
                     rq, {32'd0, got} % MODV, t % MODV);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        a_r = a;
        b_r = b;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        a_r = MAXV;
        b_r = 32'd5;
        repeat (3) begin
            @(posedge clk);
            #1;
            chk("R1 reset clears", sum_w, '0);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_no_wrap();
        apply(0, 0);                      chk("R2 zero", sum_w, 0);
        apply(1, 2);                      chk("R2 small", sum_w, 3);
        apply(32'h1234_5678, 32'h0101_0101); chk("R2 mid", sum_w, 32'h1335_5779);
        apply(32'h7FFF_FFFF, 32'h7FFF_FFFF); chk("R2 near top", sum_w, 32'hFFFF_FFFE);
    endtask

    task automatic t_wrap();
        apply(32'h8000_0000, 32'h8000_0005); chk("R3 wrap small", sum_w, 32'd8);
        apply(32'hFFFF_FF00, 32'h0000_0200); chk("R3 wrap carry chain", sum_w, 32'h0000_0103);
        apply(32'hF0F0_F0F0, 32'h1F1F_1F1F); chk("R3 wrap mixed", sum_w, 32'h1010_1012);
    endtask

    task automatic t_edge();
        apply(MAXV, 1);          chk("R4 sum 2^N", sum_w, 32'd3);
        apply(MAXV - 1, 1);      chk("R4 sum 2^N-1", sum_w, MAXV);
        apply(MAXV - 2, 3);      chk("R4 alt zero plus 3", sum_w, 32'd3);
    endtask

    task automatic t_alt();
        apply(MAXV - 2, 7);      chk("R5 alt0+7", sum_w, 32'd7);  chk_mod("R5", MAXV - 2, 7, sum_w);
        apply(MAXV - 1, 9);      chk("R5 alt1+9", sum_w, 32'd10); chk_mod("R5", MAXV - 1, 9, sum_w);
        apply(MAXV, 16);         chk("R5 alt2+16", sum_w, 32'd18); chk_mod("R5", MAXV, 16, sum_w);
        apply(MAXV - 2, 0);      chk("R5 alt0+0 stays", sum_w, MAXV - 2);
    endtask

    task automatic t_double();
        apply(MAXV, MAXV);          chk("R6 sum 2^(N+1)-2", sum_w, 32'd1);
        apply(MAXV, MAXV - 1);      chk("R6 sum 2^(N+1)-3", sum_w, 32'd0);
        apply(MAXV - 1, MAXV - 1);  chk("R7 sum 2^(N+1)-4", sum_w, MAXV);
        chk_mod("R7 near double wrap", MAXV - 1, MAXV - 1, sum_w);
    endtask

    task automatic t_latency();
        apply(5, 6);
        @(negedge clk);
        a_r = 100;
        b_r = 200;
        #1;
        chk("R8 no change before edge", sum_w, 32'd11);
        @(posedge clk);
        #1;
        chk("R8 new value after edge", sum_w, 32'd300);
        @(posedge clk);
        #1;
        chk("R8 held operands hold", sum_w, 32'd300);
    endtask

    task automatic t_random();
        for (int it = 0; it < 3000; it++) begin
            logic [W-1:0] a, b;
            logic [63:0]  t;
            a = $urandom();
            b = $urandom();
            if (it % 5 == 0) a = MAXV - W'(it % 7);
            if (it % 7 == 0) b = MAXV - W'(it % 5);
            apply(a, b);
            t = {32'd0, a} + {32'd0, b};
            chk(t[W] ? "R3 random" : "R2 random", sum_w, ref_sum(a, b));
            if (t >= (64'd2 << W) - 64'd3) n_dbl++;
            else chk_mod("R7 random congruence", a, b, sum_w);
        end
        $display("note: %0d double-wrap operand pairs seen in random run", n_dbl);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_no_wrap();
        t_wrap();
        t_edge();
        t_alt();
        t_double();
        t_latency();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule